// File: doc/BRIEF.md
# ADC Result Accumulation Reducer

This block sits between an analog-to-digital conversion source and the result register that a consumer reads. When the two-bit modification mode selects accumulation, it adds a programmable number of consecutive 12-bit conversion results into one 16-bit sum. The count comes from a 4-bit control field. Code N collects N+1 results, so code 15 collects sixteen. Code 0 turns reduction off, and each conversion is then stored as it arrives.

Beside the sum, the block exposes a valid flag and a reduction counter that counts down. The counter is loaded from the control field by the first conversion of a group and drops by one on every later conversion. A one-cycle result event marks the cycle in which a group is complete. The consumer divides the sum to obtain an average. It may only trust the sum when the valid flag is set and the counter reads zero. A sum that is not read before the next group starts keeps its flag set, but the counter is then nonzero, so the stale state can be seen.

Top module: `adc_accum_reducer`

## Requirements
- R1: After synchronous reset, the sum, valid flag, counter and result event are all zero.
- R2: With control code 0 and mode 00, each accepted conversion is written to the sum zero-extended. The valid flag sets, the event pulses and the counter stays at 0.
- R3: With control code N from 1 to 15, the sum equals the total of N+1 consecutive accepted conversions. The first conversion of a group overwrites the previous sum instead of adding to it.
- R4: The first conversion of a group loads the counter with the control code. Each further accepted conversion decrements it by one, and it reaches 0 on the last conversion of the group.
- R5: The result event is high for exactly the one cycle that follows the completing conversion. It is never high after an intermediate conversion, and whenever it is high the counter reads 0.
- R6: A completed group sets the valid flag. A read strobe clears it. When a read strobe and a completing conversion fall in the same cycle, the flag ends set.
- R7: Starting a new group does not clear an unread valid flag. The flag stays 1 while the counter shows the new nonzero count.
- R8: When the mode field is not 00 (01 filtering, 10 difference, 11 reserved), conversion strobes are ignored: the sum, counter and valid flag hold and no event is raised.
- R9: The control code is taken only at the first conversion of a group. Changing it in the middle of a group does not change the group's length.
- R10: Sixteen conversions of 4095 under code 15 produce 65520 without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Conversion-done strobe, one cycle per result |
| conv_data | input | 12 | Conversion result |
| red_ctrl | input | 4 | Reduction control code, N+1 values per group |
| mod_mode | input | 2 | Modification mode, 00 selects accumulation |
| rd_strobe | input | 1 | Consumer read strobe, clears the valid flag |
| res_sum | output | 16 | Accumulated sum (partial while counter is nonzero) |
| res_valid | output | 1 | Valid flag |
| red_cnt | output | 4 | Reduction counter, counting down |
| res_event | output | 1 | One-cycle pulse on group completion |

## Verification
The assertions assume that the conversion data is never wider than 12 bits. Under that assumption the counter limits a group to sixteen additions, so the overflow property depends only on the counter. They also assume that the mode field and control code may change on any cycle, so no property relies on them being held steady. The random stimulus draws data across the full 12-bit range and switches mode and control code freely, including in the middle of a group. Directed cases drive the all-ones group, a read in the same cycle as completion, and an unread flag carried into a new group.

// File: rtl/adc_red_pkg.sv
package adc_red_pkg;
  typedef enum logic [1:0] {
    MODE_ACCUM  = 2'b00,
    MODE_FILTER = 2'b01,
    MODE_DIFF   = 2'b10,
    MODE_RSVD   = 2'b11
  } dmode_e;
endpackage

// File: rtl/adc_red_seq.sv
module adc_red_seq
  import adc_red_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [1:0]        mod_mode,
  input  logic [CTRL_W-1:0] red_ctrl,
  output logic              start_o,
  output logic              add_o,
  output logic              done_o,
  output logic [CTRL_W-1:0] cnt_o
);
  localparam logic [CTRL_W-1:0] CNT_ONE = CTRL_W'(1);

  logic              accept;
  logic [CTRL_W-1:0] cnt_q;

  assign accept  = conv_valid && (mod_mode == MODE_ACCUM);
  assign start_o = accept && (cnt_q == '0);
  assign add_o   = accept && (cnt_q != '0);
  assign done_o  = (start_o && (red_ctrl == '0)) || (add_o && (cnt_q == CNT_ONE));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_o) begin
      cnt_q <= red_ctrl;
    end else if (add_o) begin
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  AST_CNT_DECR: assert property (@(posedge clk) disable iff (rst)
    add_o |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R4
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (cnt_q == $past(red_ctrl))); // R4
  AST_IGNORE_CNT: assert property (@(posedge clk) disable iff (rst)
    (mod_mode != MODE_ACCUM) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/adc_red_accum.sv
module adc_red_accum #(
  parameter int DATA_W = 12,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W:0]   wide_sum;

  assign wide_sum = {1'b0, acc_q} + (SUM_W+1)'(data_i);
  assign sum_o    = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (start_i) begin
      acc_q <= SUM_W'(data_i);
    end else if (add_i) begin
      acc_q <= wide_sum[SUM_W-1:0];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    add_i |-> (wide_sum[SUM_W] == 1'b0)); // R10
  AST_FIRST_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (acc_q == SUM_W'($past(data_i)))); // R3
  AST_IGNORE_ACC: assert property (@(posedge clk) disable iff (rst)
    !(start_i || add_i) |=> $stable(acc_q)); // R8
endmodule

// File: rtl/adc_red_flag.sv
module adc_red_flag #(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic              rd_i,
  input  logic [CTRL_W-1:0] cnt_i,
  output logic              valid_o,
  output logic              event_o
);
  logic valid_q;
  logic event_q;

  assign valid_o = valid_q;
  assign event_o = event_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= done_i;
      if (done_i) begin
        valid_q <= 1'b1;
      end else if (rd_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  AST_EVENT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    event_q |-> (cnt_i == '0)); // R5
  AST_EVENT_VALID: assert property (@(posedge clk) disable iff (rst)
    event_q |-> valid_q); // R6
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !done_i) |=> !valid_q); // R6
endmodule

// File: rtl/adc_accum_reducer.sv
module adc_accum_reducer #(
  parameter int DATA_W = 12,
  parameter int CTRL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     conv_valid,
  input  logic [DATA_W-1:0]        conv_data,
  input  logic [CTRL_W-1:0]        red_ctrl,
  input  logic [1:0]               mod_mode,
  input  logic                     rd_strobe,
  output logic [DATA_W+CTRL_W-1:0] res_sum,
  output logic                     res_valid,
  output logic [CTRL_W-1:0]        red_cnt,
  output logic                     res_event
);
  localparam int SUM_W = DATA_W + CTRL_W;

  logic start_w;
  logic add_w;
  logic done_w;

  adc_red_seq #(.CTRL_W(CTRL_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .conv_valid (conv_valid),
    .mod_mode   (mod_mode),
    .red_ctrl   (red_ctrl),
    .start_o    (start_w),
    .add_o      (add_w),
    .done_o     (done_w),
    .cnt_o      (red_cnt)
  );

  adc_red_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_w),
    .add_i   (add_w),
    .data_i  (conv_data),
    .sum_o   (res_sum)
  );

  adc_red_flag #(.CTRL_W(CTRL_W)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .done_i  (done_w),
    .rd_i    (rd_strobe),
    .cnt_i   (red_cnt),
    .valid_o (res_valid),
    .event_o (res_event)
  );

  AST_EVENT_ON_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && (mod_mode == 2'b00) && (red_cnt > 4'(1))) |=> !res_event); // R5
endmodule

// File: tb/adc_accum_reducer_bench.sv
`timescale 1ns/1ps
module adc_accum_reducer_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        conv_valid;
  logic [11:0] conv_data;
  logic [3:0]  red_ctrl;
  logic [1:0]  mod_mode;
  logic        rd_strobe;
  logic [15:0] res_sum;
  logic        res_valid;
  logic [3:0]  red_cnt;
  logic        res_event;

  int total = 0;
  int bad = 0;
  int m_sum, m_cnt, m_val, m_ev;

  always #10 clk = ~clk;

  adc_accum_reducer u_adc_accum_reducer (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .red_ctrl(red_ctrl), .mod_mode(mod_mode), .rd_strobe(rd_strobe),
    .res_sum(res_sum), .res_valid(res_valid), .red_cnt(red_cnt), .res_event(res_event)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference behaviour taken from the requirements.
  function automatic void model(bit cv, int data, int ctrl, int mode, bit rd);
    bit done = 0;
    m_ev = 0;
    if (cv && mode == 0) begin
      if (m_cnt == 0) begin
        m_sum = data;
        m_cnt = ctrl;
        done = (ctrl == 0);
      end else begin
        m_sum = m_sum + data;
        m_cnt = m_cnt - 1;
        done = (m_cnt == 0);
      end
    end
    if (done) begin
      m_val = 1;
      m_ev = 1;
    end else if (rd) begin
      m_val = 0;
    end
  endfunction

  task automatic step(bit cv, int data, int ctrl, int mode, bit rd);
    conv_valid = cv;
    conv_data  = 12'(data);
    red_ctrl   = 4'(ctrl);
    mod_mode   = 2'(mode);
    rd_strobe  = rd;
    @(posedge clk);
    #1;
    model(cv, data, ctrl, mode, rd);
    chk("R3 sum", int'(res_sum), m_sum);
    chk("R4 counter", int'(red_cnt), m_cnt);
    chk("R6 valid", int'(res_valid), m_val);
    chk("R5 event", int'(res_event), m_ev);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; conv_valid = 0; conv_data = 0; red_ctrl = 0; mod_mode = 0; rd_strobe = 0;
    m_sum = 0; m_cnt = 0; m_val = 0; m_ev = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 sum", int'(res_sum), 0);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 counter", int'(red_cnt), 0);
    chk("R1 event", int'(res_event), 0);

    // R2: direct store
    step(1, 100, 0, 0, 0);
    chk("R2 sum", int'(res_sum), 100);
    chk("R2 counter", int'(red_cnt), 0);
    chk("R2 event", int'(res_event), 1);
    step(1, 4095, 0, 0, 0);
    chk("R2 sum full", int'(res_sum), 4095);
    step(0, 0, 0, 0, 1);
    chk("R6 read clears", int'(res_valid), 0);

    // R3/R4/R5: group of four
    step(1, 10, 3, 0, 0);
    chk("R3 overwrite", int'(res_sum), 10);
    chk("R4 load", int'(red_cnt), 3);
    chk("R5 no event mid", int'(res_event), 0);
    step(1, 20, 3, 0, 0);
    step(1, 30, 3, 0, 0);
    chk("R4 decrement", int'(red_cnt), 1);
    step(1, 40, 3, 0, 0);
    chk("R3 group sum", int'(res_sum), 100);
    chk("R5 event end", int'(res_event), 1);
    step(0, 0, 3, 0, 0);
    chk("R5 single pulse", int'(res_event), 0);

    // R7: unread flag survives a new start
    step(1, 5, 3, 0, 0);
    chk("R7 valid kept", int'(res_valid), 1);
    chk("R7 counter nonzero", int'(red_cnt), 3);
    step(1, 5, 3, 0, 0);
    step(1, 5, 3, 0, 0);
    step(1, 5, 3, 0, 1);
    chk("R6 completion beats read", int'(res_valid), 1);
    chk("R3 group sum 2", int'(res_sum), 20);

    // R8: other modes ignored
    for (int md = 1; md < 4; md++) begin
      step(1, 999, 3, md, 0);
      chk("R8 sum held", int'(res_sum), 20);
      chk("R8 counter held", int'(red_cnt), 0);
      chk("R8 no event", int'(res_event), 0);
    end

    // R9: control change mid-group
    step(0, 0, 0, 0, 1);
    step(1, 1, 2, 0, 0);
    step(1, 1, 15, 0, 0);
    chk("R9 counter", int'(red_cnt), 1);
    step(1, 1, 0, 0, 0);
    chk("R9 length kept", int'(res_sum), 3);
    chk("R9 valid", int'(res_valid), 1);

    // R10: all-ones group of sixteen
    for (int i = 0; i < 16; i++) step(1, 4095, 15, 0, 0);
    chk("R10 max sum", int'(res_sum), 65520);
    chk("R10 event", int'(res_event), 1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 9));
      int md = (r == 0) ? int'($urandom_range(1, 3)) : 0;
      bit cv = ($urandom_range(0, 9) < 7);
      bit rd = ($urandom_range(0, 4) == 0);
      int ct = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 4));
      step(cv, int'($urandom_range(0, 4095)), ct, md, rd);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule